// File: doc/BRIEF.md
# Three-Phase Sine Sample Generator

This block produces three signed sine samples spaced a third of a turn apart, for the modulators of a three-phase motor drive. A fixed-point phase register with fractional bits advances by a programmable step on every enabled clock. Only its integer bits select an entry in a sine table. The other two phases read the same table at index offsets of one third and two thirds of the table length. Each of the three table values is multiplied by a signed amplitude word, and the upper part of the product becomes the output. The output frequency is set by the step word alone. The amplitude word sets the output swing and does not touch the phase.

A new sample triple is captured once every `PERIOD` enabled clocks, which matches the rate of the downstream modulator. The triple is presented on a valid/ready output stream. When the consumer keeps `samp_ready` high, `samp_valid` pulses for one cycle per triple. If `samp_ready` is low while `samp_valid` is high, the triple and `samp_valid` are held unchanged until the consumer takes them. Any triple captured while a triple is held is discarded, and the phase register keeps running during the hold. `en`, `phase_inc` and `amp` are plain control inputs.

Top module: `nco3_sine_gen`

## Requirements
- R1: While `rst_n` is low and after its release with `en` low, `samp_valid` is 0 and all three sample outputs are 0. The phase register starts at 0.
- R2: The 24-bit phase register adds `phase_inc` modulo 2^24 on every clock with `en` high, keeping all fractional bits. The table index is its upper 8 bits. The j-th triple after reset uses the register value ((j*PERIOD-1)*phase_inc) mod 2^24.
- R3: The table entry at index x is round(2047*sin(2*pi*x/256)), rounded half away from zero, as a 12-bit two's complement value.
- R4: With index a for phase A, phase B reads index (a+85) mod 256 and phase C reads index (a+171) mod 256.
- R5: Each output equals floor(T*amp/1024), where T is the phase's table entry and `amp` is a 10-bit two's complement value. This is the upper 12 bits of the 22-bit signed product. An `amp` of 0 gives zero outputs.
- R6: One triple is captured every PERIOD (default 8) enabled clocks. With `samp_ready` high, `samp_valid` is high for exactly one cycle per triple.
- R7: While `en` is low, the phase register and the period count hold their values and no new triple is produced. When `en` returns high, the sequence continues as though no gap had occurred.
- R8: While `samp_valid` is high and `samp_ready` is low, `samp_valid` stays high and all three sample outputs keep their values. Triples captured during this time are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance phase and period count when high |
| phase_inc | input | 24 | Phase step per clock, 8 integer and 16 fractional bits |
| amp | input | 10 | Signed amplitude multiplier |
| samp_a | output | 12 | Signed sample, phase A |
| samp_b | output | 12 | Signed sample, phase B |
| samp_c | output | 12 | Signed sample, phase C |
| samp_valid | output | 1 | Sample triple available |
| samp_ready | input | 1 | Consumer accepts the triple |

## Verification
The step words cover several cases. A step of exactly one index per clock and a half-index step test whole and half increments. A step of 0x024924 has a repeating fraction, so it shows whether fractional bits are dropped or kept across additions. A near-full-turn step (0xFF0000) moves the phase backwards, and a single-LSB step tests wrap and truncation. The amplitude values are full positive, the most negative, mid-range and zero. These show the sign of the product, the floor rounding and the zero case. Separate runs check the hold under a stalled consumer, and they check that a gap in `en` shifts neither the phase nor the capture points.

// File: rtl/nco3_pkg.sv
package nco3_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Rounded sine table point, computed by series at elaboration time.
  function automatic int sine_point(input int idx, input int depth, input int peak);
    real x;
    real term;
    real sum;
    real scaled;
    x = 2.0 * PI_R * real'(idx) / real'(depth);
    if (x > PI_R) x = x - 2.0 * PI_R;
    term = x;
    sum  = x;
    for (int k = 1; k <= 11; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    scaled = sum * real'(peak);
    if (scaled >= 0.0) return $rtoi(scaled + 0.5);
    return -$rtoi(0.5 - scaled);
  endfunction

endpackage

// File: rtl/nco3_phase_acc.sv
module nco3_phase_acc #(
  parameter int ACC_W  = 24,
  parameter int PERIOD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc,
  output logic             tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_q + inc;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign acc  = acc_q;
  assign tick = en && (cnt_q == LAST);

  AST_ACC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q) && $stable(cnt_q)); // R7

  generate
    if (PERIOD > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
    end
  endgenerate
endmodule

// File: rtl/nco3_sine_rom.sv
module nco3_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 12,
  parameter int OFFSET = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic [ADDR_W-1:0]        phase_addr,
  output logic signed [SAMP_W-1:0] samp
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << (SAMP_W - 1)) - 1;

  logic signed [SAMP_W-1:0] tbl [DEPTH];
  logic [ADDR_W-1:0] rd_addr;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
      localparam int V = nco3_pkg::sine_point(i, DEPTH, PEAK);
      assign tbl[i] = SAMP_W'(V);
    end
  endgenerate

  assign rd_addr = phase_addr + ADDR_W'(OFFSET);

  always_ff @(posedge clk) begin
    if (!rst_n) samp <= '0;
    else if (ld) samp <= tbl[rd_addr];
  end
endmodule

// File: rtl/nco3_scaler.sv
module nco3_scaler #(
  parameter int SAMP_W = 12,
  parameter int AMP_W  = 10
) (
  input  logic signed [SAMP_W-1:0] samp,
  input  logic signed [AMP_W-1:0]  amp,
  output logic signed [SAMP_W-1:0] scaled
);
  localparam int PROD_W = SAMP_W + AMP_W;

  logic signed [PROD_W-1:0] prod;

  assign prod   = PROD_W'(samp) * PROD_W'(amp);
  assign scaled = prod[PROD_W-1 -: SAMP_W];
endmodule

// File: rtl/nco3_sine_gen.sv
module nco3_sine_gen #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 12,
  parameter int AMP_W  = 10,
  parameter int PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  phase_inc,
  input  logic [AMP_W-1:0]  amp,
  output logic [SAMP_W-1:0] samp_a,
  output logic [SAMP_W-1:0] samp_b,
  output logic [SAMP_W-1:0] samp_c,
  output logic              samp_valid,
  input  logic              samp_ready
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PHASES = 3;

  logic [ACC_W-1:0]  acc;
  logic              tick;
  logic              s1_valid;
  logic              load;
  logic [ADDR_W-1:0] base_addr;
  logic signed [SAMP_W-1:0] raw    [PHASES];
  logic signed [SAMP_W-1:0] scaled [PHASES];
  logic signed [SAMP_W-1:0] out_q  [PHASES];

  nco3_phase_acc #(.ACC_W(ACC_W), .PERIOD(PERIOD)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .inc(phase_inc), .acc(acc), .tick(tick)
  );

  assign base_addr = acc[ACC_W-1 -: ADDR_W];

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
      nco3_sine_rom #(
        .ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .OFFSET((p * DEPTH + 1) / PHASES)
      ) u_rom (
        .clk(clk), .rst_n(rst_n), .ld(tick), .phase_addr(base_addr), .samp(raw[p])
      );
      nco3_scaler #(.SAMP_W(SAMP_W), .AMP_W(AMP_W)) u_scale (
        .samp(raw[p]), .amp(amp), .scaled(scaled[p])
      );
    end
  endgenerate

  assign load = s1_valid && (!samp_valid || samp_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      samp_valid <= 1'b0;
      for (int p = 0; p < PHASES; p++) out_q[p] <= '0;
    end else begin
      s1_valid <= tick;
      if (load) begin
        samp_valid <= 1'b1;
        for (int p = 0; p < PHASES; p++) out_q[p] <= scaled[p];
      end else if (samp_ready) begin
        samp_valid <= 1'b0;
      end
    end
  end

  assign samp_a = out_q[0];
  assign samp_b = out_q[1];
  assign samp_c = out_q[2];

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    samp_valid && !samp_ready |=> samp_valid && $stable(samp_a) && $stable(samp_b) && $stable(samp_c)); // R8
  AST_PIPE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !(samp_valid && !samp_ready) |=> samp_valid); // R6
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_valid) |-> $past(s1_valid)); // R6
  AST_ZERO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    load && (amp == '0) |=> samp_a == '0 && samp_b == '0 && samp_c == '0); // R5
endmodule

// File: tb/nco3_sine_gen_bench.sv
module nco3_sine_gen_bench;
  localparam int PER = 8;
  localparam int NV  = 8;
  // {phase_inc[23:0], amp[9:0], expected first phase-A index[7:0]}
  localparam logic [41:0] VEC [NV] = '{
    {24'h010000, 10'h1FF, 8'd7},
    {24'h008000, 10'h1FF, 8'd3},
    {24'h0A0000, 10'h200, 8'd70},
    {24'h000001, 10'd300, 8'd0},
    {24'h200000, 10'd256, 8'd224},
    {24'hFF0000, 10'd100, 8'd249},
    {24'h024924, 10'h1FF, 8'd15},
    {24'h030000, 10'd0,   8'd21}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [23:0] phase_inc = '0;
  logic [9:0] amp = '0;
  logic [11:0] samp_a, samp_b, samp_c;
  logic samp_valid;
  logic samp_ready = 1'b1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nco3_sine_gen u_nco3_sine_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_inc(phase_inc), .amp(amp),
    .samp_a(samp_a), .samp_b(samp_b), .samp_c(samp_c),
    .samp_valid(samp_valid), .samp_ready(samp_ready)
  );

  function automatic int tbl_val(input int x);
    real v;
    v = 2047.0 * $sin(2.0 * 3.14159265358979323846 * real'(x) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int exp_out(input int x, input logic [9:0] a);
    int av;
    int prod;
    av = int'($signed(a));
    prod = tbl_val(x % 256) * av;
    return prod >>> 10;
  endfunction

  function automatic int idx_of(input int j, input logic [23:0] inc);
    longint unsigned v;
    v = (longint'(j * PER - 1) * longint'(inc)) % 64'h1000000;
    return int'(v >> 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (samp_valid) begin
        got = 1;
        break;
      end
    end
    chk(got, "R6 valid timeout", 0, 1);
  endtask

  task automatic check_triple(input int j, input logic [23:0] inc, input logic [9:0] a);
    int ia;
    ia = idx_of(j, inc);
    chk($signed(samp_a) == exp_out(ia, a), "R3/R5 phase A", $signed(samp_a), exp_out(ia, a));
    chk($signed(samp_b) == exp_out(ia + 85, a), "R4 phase B", $signed(samp_b), exp_out(ia + 85, a));
    chk($signed(samp_c) == exp_out(ia + 171, a), "R4 phase C", $signed(samp_c), exp_out(ia + 171, a));
  endtask

  initial begin
    bit got;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(samp_valid == 1'b0, "R1 valid in reset", samp_valid, 0);
    chk(samp_a == '0 && samp_b == '0 && samp_c == '0, "R1 samples in reset", $signed(samp_a), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(samp_valid == 1'b0, "R1 idle with en low", samp_valid, 0);

    // vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      do_reset();
      phase_inc = VEC[v][41:18];
      amp = VEC[v][17:8];
      samp_ready = 1'b1;
      en = 1'b1;
      for (int j = 1; j <= 3; j++) begin
        wait_valid(got);
        if (j == 1)
          chk(idx_of(1, phase_inc) == int'(VEC[v][7:0]), "R2 first index", idx_of(1, phase_inc), int'(VEC[v][7:0]));
        check_triple(j, phase_inc, amp);
        @(negedge clk);
        chk(samp_valid == 1'b0, "R6 one-cycle pulse", samp_valid, 0);
      end
    end

    // R7 enable gap keeps sequence
    do_reset();
    phase_inc = 24'h0B3000;
    amp = 10'd400;
    en = 1'b1;
    wait_valid(got);
    check_triple(1, phase_inc, amp);
    en = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (samp_valid) chk(1'b0, "R7 no output while disabled", 1, 0);
    end
    chk(samp_valid == 1'b0, "R7 idle after gap", samp_valid, 0);
    en = 1'b1;
    wait_valid(got);
    check_triple(2, phase_inc, amp); // R7 continuation
    wait_valid(got);
    check_triple(3, phase_inc, amp);

    // R8 back-pressure hold
    do_reset();
    phase_inc = 24'h010000;
    amp = 10'h1FF;
    samp_ready = 1'b0;
    en = 1'b1;
    wait_valid(got);
    check_triple(1, phase_inc, amp);
    for (int n = 0; n < 30; n++) @(negedge clk);
    chk(samp_valid == 1'b1, "R8 valid held", samp_valid, 1);
    chk($signed(samp_a) == exp_out(idx_of(1, phase_inc), amp), "R8 data held",
        $signed(samp_a), exp_out(idx_of(1, phase_inc), amp));
    samp_ready = 1'b1;
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule